// File: doc/BRIEF.md
# Strobe Write-Leveling Training Engine

This block sits in a memory controller and trains the launch delay of every data-strobe lane so that the strobe reaches the memory aligned to the memory clock. It first asks the memory to enter its leveling mode through a mode-register write request. It then works on one lane at a time. For each lane it sets a trial delay, waits a programmable number of settle cycles and requests one strobe burst. It then reads back the clock level that the memory sampled for that lane. The trial delay sweeps upward from zero. The first sample that reads 1 right after a sample that read 0 fixes the lane's delay.

If a lane reaches its largest tap without such a transition, the lane is flagged as failed and the next lane starts. When the last lane has been handled, the engine issues a second mode-register write that leaves leveling mode. Once that write is acknowledged, it pulses `done`. The trained delays and the per-lane failure flags stay on the outputs until the next `start`.

Top module: `wl_train_top`

## Requirements
- R1: After reset, `busy`, `done`, `strobe_req`, `mrw_req`, every `lane_err` bit and every `lane_delay` field are 0.
- R2: A `start` while idle raises `mrw_req` with `mrw_idx` = 1 and `mrw_wdata` holding only bit 7 set. The request and its content stay unchanged until the cycle in which `mrw_ack` is seen.
- R3: `strobe_req` is raised only after the entry write has been acknowledged and before the exit write is requested, and never while `mrw_req` is high.
- R4: For the lane under training, the delay field starts at 0. After each feedback that neither locks nor fails, it rises by exactly one. A lane whose feedback first reads 1 at tap s (1 <= s <= maximum) therefore takes s+1 bursts.
- R5: After the entry acknowledgement and after each accepted feedback, at least `settle_cycles` cycles pass before the next `strobe_req`. The value used is the one captured with `start`.
- R6: When the feedback bit of the active lane (bit i of `fb_bits` for lane i) reads 1 and the previous feedback of the same lane read 0, the lane locks. Its field keeps the current tap and its `lane_err` bit stays 0.
- R7: If the active lane gets feedback at the all-ones tap without locking, its `lane_err` bit is set, its field holds the all-ones tap and the next lane begins. Such a lane takes 2^TAP_W bursts.
- R8: Lanes are trained in increasing index order, one at a time. Lane i's delay is the field `lane_delay[i*TAP_W +: TAP_W]`. Fields of lanes not yet trained stay 0, and finished lanes do not change.
- R9: After the last lane, `mrw_req` is raised with `mrw_idx` = 1 and `mrw_wdata` = 0. In the cycle after `mrw_ack`, `done` is high for exactly one cycle, and `busy` is already low in that cycle.
- R10: `start` has no effect while `busy` is high: the run finishes with one `done` and the same results.
- R11: `strobe_req` is a one-cycle pulse. A new one is not raised before the feedback of the previous one is accepted. `fb_valid` has no effect except while feedback is awaited.
- R12: Delays and failure flags hold their values while idle. A new `start` clears them all to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a training run (ignored while busy) |
| settle_cycles | input | SETTLE_W | Settle wait before each burst, captured at start |
| mrw_req | output | 1 | Mode-register write request, held until acknowledged |
| mrw_idx | output | 4 | Mode-register index of the request |
| mrw_wdata | output | MRW_W | Mode-register write data |
| mrw_ack | input | 1 | Acknowledge of the mode-register write |
| strobe_req | output | 1 | One-cycle request for one strobe burst |
| fb_valid | input | 1 | Sampled-clock feedback is valid this cycle |
| fb_bits | input | LANES | Sampled clock level, one bit per lane |
| lane_delay | output | LANES*TAP_W | Per-lane strobe delay: trial value while training, result afterwards |
| busy | output | 1 | A training run is in progress |
| done | output | 1 | One-cycle pulse at the end of a run |
| lane_err | output | LANES | Per-lane failure flags |

## Verification
The bench sweeps the hidden per-lane skew over every value from 0 to one past the largest tap. This reaches the cases where the first sample already reads 1 and where no sample ever reads 1. A design that locked on a plain 1 rather than on a 0-to-1 change would report tap 0 instead of a failure. A design that stopped one tap short would miss the lock at the top tap or give the wrong burst count. Settle counts of 0 and above are combined with a spurious feedback pulse and a repeated `start` mid-run. An off-by-one settle window, acceptance of stray feedback, or a restart would show up as spacing violations, false locks or extra `done` pulses. The mode-register writes are logged and their order and content are compared.

// File: rtl/wl_pkg.sv
// Package: shared types of the write-leveling training engine.
// Assumes: nothing beyond IEEE 1800-2017.
package wl_pkg;

    // Training sequencer states
    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_ENTER  = 3'd1,
        ST_SETTLE = 3'd2,
        ST_PULSE  = 3'd3,
        ST_WAIT   = 3'd4,
        ST_EXIT   = 3'd5
    } wl_state_t;

endpackage

// File: rtl/wl_settle_timer.sv
// Module: down-counter that spaces each strobe burst from the preceding
// delay update. Assumes load and tick are never high together.
module wl_settle_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         tick,
    output logic         expired
);

    logic [W-1:0] cnt;

    // Load the wait length, then count down to zero
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (tick && (cnt != '0)) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign expired = (cnt == '0);

endmodule

// File: rtl/wl_step_eval.sv
// Module: judges one feedback sample of the active lane.
// Assumes: prev_bit is meaningful only when have_prev is set.
module wl_step_eval #(
    parameter int TAP_W = 6
) (
    input  logic             fb_bit,
    input  logic             prev_bit,
    input  logic             have_prev,
    input  logic [TAP_W-1:0] tap,
    output logic             lock,
    output logic             fail
);

    localparam logic [TAP_W-1:0] TAP_TOP = {TAP_W{1'b1}};

    // A rising feedback between two consecutive samples locks the lane;
    // otherwise the top tap ends the sweep as a failure
    always_comb begin
        lock = have_prev && !prev_bit && fb_bit;
        fail = !lock && (tap == TAP_TOP);
    end

endmodule

// File: rtl/wl_delay_bank.sv
// Module: per-lane delay and failure storage, one register set per lane.
// Assumes: wr_lane < LANES; clr has priority over writes.
module wl_delay_bank #(
    parameter int LANES  = 8,
    parameter int TAP_W  = 6,
    parameter int LANE_W = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clr,
    input  logic                    wr_en,
    input  logic [LANE_W-1:0]       wr_lane,
    input  logic [TAP_W-1:0]        wr_val,
    input  logic                    err_set,
    output logic [LANES*TAP_W-1:0]  delays,
    output logic [LANES-1:0]        errs
);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [TAP_W-1:0] dly_q;
        logic             err_q;
        logic             hit;

        assign hit = (wr_lane == LANE_W'(g));

        // Hold this lane's delay and failure flag
        always_ff @(posedge clk) begin
            if (!rst_n || clr) begin
                dly_q <= '0;
                err_q <= 1'b0;
            end else begin
                if (wr_en && hit) begin
                    dly_q <= wr_val;
                end
                if (err_set && hit) begin
                    err_q <= 1'b1;
                end
            end
        end

        assign delays[g*TAP_W +: TAP_W] = dly_q;
        assign errs[g]                  = err_q;
    end

endmodule

// File: rtl/wl_train_top.sv
// Module: write-leveling training sequencer. It enters leveling mode by a
// mode-register write and sweeps each lane's strobe delay upward from zero,
// one burst per step, until the sampled clock rises from 0 to 1. It then
// leaves leveling mode and pulses done.
// Assumes: the feedback for a burst arrives as one fb_valid pulse after
// strobe_req; the mode-register agent acknowledges each held request once.
module wl_train_top #(
    parameter int LANES    = 8,
    parameter int TAP_W    = 6,
    parameter int SETTLE_W = 8,
    parameter int MRW_W    = 16,
    parameter int MR_IDX   = 1,
    parameter int LVL_BIT  = 7
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    input  logic [SETTLE_W-1:0]     settle_cycles,
    output logic                    mrw_req,
    output logic [3:0]              mrw_idx,
    output logic [MRW_W-1:0]        mrw_wdata,
    input  logic                    mrw_ack,
    output logic                    strobe_req,
    input  logic                    fb_valid,
    input  logic [LANES-1:0]        fb_bits,
    output logic [LANES*TAP_W-1:0]  lane_delay,
    output logic                    busy,
    output logic                    done,
    output logic [LANES-1:0]        lane_err
);

    import wl_pkg::*;

    localparam int               LANE_W   = (LANES > 1) ? $clog2(LANES) : 1;
    localparam logic [LANE_W-1:0] LANE_LAST = LANE_W'(LANES - 1);
    localparam logic [MRW_W-1:0]  MRW_ON    = MRW_W'(1) << LVL_BIT;

    wl_state_t             state;
    logic [LANE_W-1:0]     lane;
    logic [TAP_W-1:0]      tap;
    logic                  prev_bit;
    logic                  have_prev;
    logic [SETTLE_W-1:0]   settle_q;

    logic                  fb_bit;
    logic                  step_lock;
    logic                  step_fail;
    logic                  tmr_load;
    logic                  tmr_tick;
    logic                  tmr_expired;
    logic                  bank_clr;
    logic                  bank_wr;
    logic [TAP_W-1:0]      bank_val;
    logic                  bank_err;
    logic                  fb_take;

    assign fb_bit  = fb_bits[lane];
    assign fb_take = (state == ST_WAIT) && fb_valid;

    wl_step_eval #(.TAP_W(TAP_W)) u_eval (
        .fb_bit    (fb_bit),
        .prev_bit  (prev_bit),
        .have_prev (have_prev),
        .tap       (tap),
        .lock      (step_lock),
        .fail      (step_fail)
    );

    wl_settle_timer #(.W(SETTLE_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (settle_q),
        .tick     (tmr_tick),
        .expired  (tmr_expired)
    );

    wl_delay_bank #(.LANES(LANES), .TAP_W(TAP_W), .LANE_W(LANE_W)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (bank_clr),
        .wr_en   (bank_wr),
        .wr_lane (lane),
        .wr_val  (bank_val),
        .err_set (bank_err),
        .delays  (lane_delay),
        .errs    (lane_err)
    );

    // Derive timer and result-bank controls from the current step
    always_comb begin
        bank_clr = (state == ST_IDLE) && start;
        bank_wr  = 1'b0;
        bank_val = tap + 1'b1;
        bank_err = 1'b0;
        tmr_load = 1'b0;
        tmr_tick = (state == ST_SETTLE) && !tmr_expired;
        if ((state == ST_ENTER) && mrw_ack) begin
            tmr_load = 1'b1;
        end
        if (fb_take) begin
            if (step_lock || step_fail) begin
                bank_err = step_fail;
                tmr_load = (lane != LANE_LAST);
            end else begin
                bank_wr  = 1'b1;
                tmr_load = 1'b1;
            end
        end
    end

    // Sequence mode entry, per-lane sweeps and mode exit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            lane      <= '0;
            tap       <= '0;
            prev_bit  <= 1'b0;
            have_prev <= 1'b0;
            settle_q  <= '0;
            done      <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        settle_q <= settle_cycles;
                        state    <= ST_ENTER;
                    end
                end
                ST_ENTER: begin
                    if (mrw_ack) begin
                        lane      <= '0;
                        tap       <= '0;
                        have_prev <= 1'b0;
                        state     <= ST_SETTLE;
                    end
                end
                ST_SETTLE: begin
                    if (tmr_expired) begin
                        state <= ST_PULSE;
                    end
                end
                ST_PULSE: begin
                    state <= ST_WAIT;
                end
                ST_WAIT: begin
                    if (fb_valid) begin
                        if (step_lock || step_fail) begin
                            if (lane == LANE_LAST) begin
                                state <= ST_EXIT;
                            end else begin
                                lane      <= lane + 1'b1;
                                tap       <= '0;
                                have_prev <= 1'b0;
                                state     <= ST_SETTLE;
                            end
                        end else begin
                            tap       <= tap + 1'b1;
                            prev_bit  <= fb_bit;
                            have_prev <= 1'b1;
                            state     <= ST_SETTLE;
                        end
                    end
                end
                ST_EXIT: begin
                    if (mrw_ack) begin
                        done  <= 1'b1;
                        state <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign busy       = (state != ST_IDLE);
    assign strobe_req = (state == ST_PULSE);
    assign mrw_req    = (state == ST_ENTER) || (state == ST_EXIT);
    assign mrw_idx    = 4'(MR_IDX);
    assign mrw_wdata  = (state == ST_ENTER) ? MRW_ON : '0;

endmodule

// File: rtl/wl_train_chk.sv
// Module: protocol checker for wl_train_top, bound to every instance.
// Assumes: port names match the top module so the bind can connect by name.
module wl_train_chk #(
    parameter int LANES    = 8,
    parameter int TAP_W    = 6,
    parameter int SETTLE_W = 8,
    parameter int MRW_W    = 16
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    start,
    input logic [SETTLE_W-1:0]     settle_cycles,
    input logic                    mrw_req,
    input logic [3:0]              mrw_idx,
    input logic [MRW_W-1:0]        mrw_wdata,
    input logic                    mrw_ack,
    input logic                    strobe_req,
    input logic                    fb_valid,
    input logic [LANES-1:0]        fb_bits,
    input logic [LANES*TAP_W-1:0]  lane_delay,
    input logic                    busy,
    input logic                    done,
    input logic [LANES-1:0]        lane_err
);

    logic [SETTLE_W-1:0] set_q;
    logic [SETTLE_W:0]   quiet;
    logic                awaiting;

    // Capture the settle length the way a correct engine must see it
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            set_q <= '0;
        end else if (start && !busy) begin
            set_q <= settle_cycles;
        end
    end

    // Track outstanding bursts and cycles since the last accepted event
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            awaiting <= 1'b0;
            quiet    <= '0;
        end else begin
            if (strobe_req) begin
                awaiting <= 1'b1;
            end else if (fb_valid) begin
                awaiting <= 1'b0;
            end
            if ((awaiting && fb_valid) || (mrw_req && mrw_ack)) begin
                quiet <= '0;
            end else if (quiet != {(SETTLE_W+1){1'b1}}) begin
                quiet <= quiet + 1'b1;
            end
        end
    end

    assert_mrw_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mrw_req && !mrw_ack) |=> (mrw_req && $stable(mrw_wdata) && $stable(mrw_idx)));

    assert_no_strobe_in_mrw_R3: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_req |-> (busy && !mrw_req));

    assert_settle_gap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_req |-> (quiet >= {1'b0, set_q}));

    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    assert_strobe_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_req |=> !strobe_req);

    assert_one_outstanding_R11: assert property (@(posedge clk) disable iff (!rst_n)
        awaiting |-> !strobe_req);

    assert_hold_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> ($stable(lane_delay) && $stable(lane_err)));

    for (genvar g = 0; g < LANES; g++) begin : g_err
        assert_err_at_max_R7: assert property (@(posedge clk) disable iff (!rst_n)
            lane_err[g] |-> (lane_delay[g*TAP_W +: TAP_W] == {TAP_W{1'b1}}));
    end

endmodule

bind wl_train_top wl_train_chk #(
    .LANES(LANES), .TAP_W(TAP_W), .SETTLE_W(SETTLE_W), .MRW_W(MRW_W)
) u_chk (.*);

// File: tb/wl_train_top_tb.sv
`timescale 1ns/1ps
// Bench: sweeps every hidden skew on every lane, with several settle
// lengths, a stray feedback pulse and a repeated start.
module wl_train_top_tb;

    localparam int LANES    = 4;
    localparam int TAP_W    = 3;
    localparam int SETTLE_W = 4;
    localparam int MRW_W    = 16;
    localparam int TOP      = (1 << TAP_W) - 1;

    logic                    clk = 1'b0;
    logic                    rst_n = 1'b0;
    logic                    start = 1'b0;
    logic [SETTLE_W-1:0]     settle_cycles = '0;
    logic                    mrw_req;
    logic [3:0]              mrw_idx;
    logic [MRW_W-1:0]        mrw_wdata;
    logic                    mrw_ack = 1'b0;
    logic                    strobe_req;
    logic                    fb_valid = 1'b0;
    logic [LANES-1:0]        fb_bits = '0;
    logic [LANES*TAP_W-1:0]  lane_delay;
    logic                    busy;
    logic                    done;
    logic [LANES-1:0]        lane_err;

    wl_train_top #(.LANES(LANES), .TAP_W(TAP_W), .SETTLE_W(SETTLE_W), .MRW_W(MRW_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .settle_cycles(settle_cycles),
        .mrw_req(mrw_req), .mrw_idx(mrw_idx), .mrw_wdata(mrw_wdata), .mrw_ack(mrw_ack),
        .strobe_req(strobe_req), .fb_valid(fb_valid), .fb_bits(fb_bits),
        .lane_delay(lane_delay), .busy(busy), .done(done), .lane_err(lane_err)
    );

    always #2.5 clk = ~clk;

    int n_chk = 0;
    int n_err = 0;
    int skew [LANES];
    int bursts, done_cnt, wlog_n, quiet, mack_cnt, pend;
    int spacing_bad, window_bad, order_bad, pulse_bad, done_busy_bad;
    logic [MRW_W-1:0]       wlog_data [2];
    logic [3:0]             wlog_idx [2];
    logic [LANES-1:0]       pend_word;
    logic [LANES*TAP_W-1:0] last_dly;
    logic                   last_strobe;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int dly_of(input int i);
        return int'(lane_delay[i*TAP_W +: TAP_W]);
    endfunction

    // Memory-side model: mode-register acks, feedback, and port monitors
    always @(negedge clk) begin
        if (rst_n) begin
            if (fb_valid || mrw_ack || (lane_delay != last_dly)) quiet = 0;
            else quiet++;
            last_dly = lane_delay;
            if (done) begin
                done_cnt++;
                if (busy) done_busy_bad++;
            end
            if (strobe_req && last_strobe) pulse_bad++;
            last_strobe = strobe_req;
            if (strobe_req) begin
                bursts++;
                if (quiet < int'(settle_cycles)) spacing_bad++;
                if (wlog_n != 1 || mrw_req) window_bad++;
                for (int j = 1; j < LANES; j++)
                    if (dly_of(j) != 0)
                        for (int i = 0; i < j; i++)
                            if (dly_of(i) == 0) order_bad++;
                for (int i = 0; i < LANES; i++)
                    pend_word[i] = (dly_of(i) >= skew[i]);
                pend = 3;
            end
            fb_valid = 1'b0;
            if (pend > 0) begin
                pend--;
                if (pend == 0) begin
                    fb_valid = 1'b1;
                    fb_bits  = pend_word;
                end
            end
            if (mrw_ack) begin
                mrw_ack  = 1'b0;
                mack_cnt = 0;
            end else if (mrw_req) begin
                mack_cnt++;
                if (mack_cnt == 1 && wlog_n == 0) begin
                    fb_valid = 1'b1;       // stray feedback, must be ignored (R11)
                    fb_bits  = '1;
                end
                if (mack_cnt == 3) begin
                    mrw_ack = 1'b1;
                    if (wlog_n < 2) begin
                        wlog_data[wlog_n] = mrw_wdata;
                        wlog_idx[wlog_n]  = mrw_idx;
                    end
                    wlog_n++;
                end
            end
        end
    end

    task automatic run_case(input int s0, input int s1, input int s2, input int s3,
                            input int settle, input bit poke);
        int t;
        int exp_bursts;
        logic [LANES*TAP_W-1:0] hold_dly;
        logic [LANES-1:0]       hold_err;
        skew[0] = s0; skew[1] = s1; skew[2] = s2; skew[3] = s3;
        bursts = 0; done_cnt = 0; wlog_n = 0; mack_cnt = 0; pend = 0;
        spacing_bad = 0; window_bad = 0; order_bad = 0; pulse_bad = 0; done_busy_bad = 0;
        @(negedge clk);
        settle_cycles = SETTLE_W'(settle);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(lane_err == '0 && lane_delay == '0 && busy, "R12 start clears results",
            int'(lane_err), 0);
        if (poke) begin
            t = 0;
            while (bursts < 5 && done_cnt == 0 && t < 4000) begin
                @(negedge clk);
                t++;
            end
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        t = 0;
        while (done_cnt == 0 && t < 4000) begin
            @(negedge clk);
            t++;
        end
        chk(done_cnt > 0, "R9 run ends with done (watchdog)", t, 0);
        repeat (6) @(negedge clk);
        exp_bursts = 0;
        for (int i = 0; i < LANES; i++) begin
            bit ok_lane = (skew[i] >= 1) && (skew[i] <= TOP);
            exp_bursts += ok_lane ? skew[i] + 1 : TOP + 1;
            if (ok_lane) begin
                chk(dly_of(i) == skew[i], "R6 locked delay", dly_of(i), skew[i]);
                chk(lane_err[i] == 1'b0, "R6 no error on lock", int'(lane_err[i]), 0);
            end else begin
                chk(dly_of(i) == TOP, "R7 failed lane holds top tap", dly_of(i), TOP);
                chk(lane_err[i] == 1'b1, "R7 error flag", int'(lane_err[i]), 1);
            end
        end
        chk(bursts == exp_bursts, "R4 burst count of sweep", bursts, exp_bursts);
        chk(wlog_n == 2, "R2 two mode-register writes", wlog_n, 2);
        chk(wlog_idx[0] == 4'd1 && wlog_data[0] == 16'h0080, "R2 entry write content",
            int'(wlog_data[0]), 16'h0080);
        chk(wlog_idx[1] == 4'd1 && wlog_data[1] == 16'h0000, "R9 exit write content",
            int'(wlog_data[1]), 0);
        chk(done_cnt == 1, poke ? "R10 single done despite restart" : "R9 single done",
            done_cnt, 1);
        chk(done_busy_bad == 0 && !busy, "R9 busy low with done", done_busy_bad, 0);
        chk(spacing_bad == 0, "R5 settle spacing", spacing_bad, 0);
        chk(window_bad == 0, "R3 strobe inside leveling window", window_bad, 0);
        chk(order_bad == 0, "R8 lane order", order_bad, 0);
        chk(pulse_bad == 0, "R11 one-cycle strobe", pulse_bad, 0);
        hold_dly = lane_delay;
        hold_err = lane_err;
        repeat (20) @(negedge clk);
        chk(lane_delay == hold_dly && lane_err == hold_err, "R12 results held while idle",
            int'(lane_err), int'(hold_err));
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        int settles [4];
        settles[0] = 0; settles[1] = 1; settles[2] = 2; settles[3] = 5;
        last_dly = '0;
        last_strobe = 1'b0;
        for (int i = 0; i < LANES; i++) skew[i] = 0;
        repeat (4) @(negedge clk);
        chk(!busy && !done && !strobe_req && !mrw_req, "R1 reset control outputs",
            int'({busy, done, strobe_req, mrw_req}), 0);
        chk(lane_delay == '0 && lane_err == '0, "R1 reset results", int'(lane_delay), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        for (int s = 0; s <= TOP + 1; s++) begin
            run_case(s, (s + 2) % (TOP + 2), (s + 4) % (TOP + 2), (s + 7) % (TOP + 2),
                     settles[s % 4], s == 3);
        end
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule